// File: doc/BRIEF.md
# EEPROM Status and Block-Protect Unit

This unit keeps the status byte of a small serial EEPROM and decides, cycle by cycle, whether a write may begin. It takes decoded command pulses from the serial front end (set the enable latch, clear it, write the protect bits, commit an array write at an address), the level of the hardware write-protect pin, and a busy level from the write-cycle timer. It returns the status byte, a flag that says whether a write command would be accepted now, a start pulse for each kind of write cycle, and a protected flag for a query address.

The two protect bits model non-volatile storage. They are plain registers that only the full reset clears. A status write does not change them at once. The new value is held aside while the write cycle runs, and it replaces the old value only when the cycle ends. At that same point the enable latch clears. An array write to a protected address is dropped and no cycle starts. While any write cycle is in progress, the unit ignores every command, but the status byte stays readable.

Top module: `nvm_status_ctrl`

## Requirements
- R1: The status byte is {4'b1111, BP[1:0], WEL, WIP}: bit 0 is WIP, bit 1 is WEL, bits 3:2 are the protect bits, and bits 7:4 always read 1. After reset it reads 0xF0.
- R2: With the write-protect pin high and no cycle in progress, a set-enable pulse sets WEL on the next cycle and a clear-enable pulse clears it. When both pulses arrive in the same cycle, clear wins.
- R3: While the write-protect pin is low, WEL reads 0 from the next cycle on, a set-enable pulse has no effect, and no write cycle starts.
- R4: A status write with WEL clear produces no start pulse and leaves BP unchanged. With WEL set, it raises the status-start output in the same cycle and captures the 2-bit data as the new BP.
- R5: An array-write commit with WEL set raises the array-start output in the same cycle only if the address is not protected. In either case WEL reads 0 on the next cycle.
- R6: The protected flag follows BP as follows: 00 protects no address, 01 protects 0xC0 to 0xFF, 10 protects 0x80 to 0xFF, and 11 protects every address.
- R7: While a status write cycle runs, BP reads its old value. The new BP appears, and WEL clears, in the same cycle in which WIP returns to 0.
- R8: WIP reads 1 from the cycle after any start pulse until the timer busy level has dropped and any pending protect update has been applied.
- R9: While WIP is 1, set-enable, clear-enable, status-write and array-write commands are ignored.
- R10: Pulling the write-protect pin low after a status write cycle has started does not cancel it. The new BP is still applied.
- R11: The write-permitted output is 1 exactly when WEL is set, the write-protect pin is high and WIP is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low full reset, released synchronously |
| cmd_set_en_i | input | 1 | Set-enable command pulse |
| cmd_clr_en_i | input | 1 | Clear-enable command pulse |
| cmd_sr_wr_i | input | 1 | Status-write command pulse |
| sr_bp_i | input | 2 | Protect bits carried by the status write |
| cmd_arr_wr_i | input | 1 | Array-write commit pulse |
| arr_addr_i | input | ADDR_W | Array-write address |
| wp_n_i | input | 1 | Hardware write-protect pin; low blocks writes |
| busy_i | input | 1 | Write-cycle timer busy level |
| chk_addr_i | input | ADDR_W | Query address for the protected flag |
| status_o | output | 8 | Status byte |
| wr_allowed_o | output | 1 | A write command would be accepted now |
| chk_prot_o | output | 1 | The query address is protected |
| sr_wr_start_o | output | 1 | Status write cycle start pulse |
| arr_wr_start_o | output | 1 | Array write cycle start pulse |

## Verification
The assertions check several rules on every cycle:
- a low protect pin clears the enable latch and blocks every start pulse;
- the enable latch only rises after an accepted set command and holds while a cycle runs;
- the protect bits stay frozen while the timer is busy;
- a start pulse always raises WIP;
- protect code 11 marks every address.

The directed scenarios show what needs a sequence of commands:
- the old protect bits are still visible during a status write, and the new ones appear only as WIP falls;
- commands are dropped while a cycle runs;
- each protect code maps to its address boundaries;
- a protected array write is dropped;
- a status write completes even when the protect pin drops mid-cycle.

// File: rtl/nvm_stat_pkg.sv
package nvm_stat_pkg;
  typedef enum logic [1:0] {
    PROT_NONE    = 2'b00,
    PROT_QUARTER = 2'b01,
    PROT_HALF    = 2'b10,
    PROT_ALL     = 2'b11
  } prot_code_e;

  localparam int          STAT_W  = 8;
  localparam int          SR_WIP  = 0;
  localparam int          SR_WEL  = 1;
  localparam int          SR_BPLO = 2;
  localparam logic [3:0]  SR_ONES = 4'hF;
endpackage

// File: rtl/nvm_prot_decode.sv
module nvm_prot_decode
  import nvm_stat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  prot_code_e        code_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              prot_o
);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);

  always_comb begin
    unique case (code_i)
      PROT_NONE:    prot_o = 1'b0;
      PROT_QUARTER: prot_o = (addr_i >= QTR_BASE);
      PROT_HALF:    prot_o = (addr_i >= HALF_BASE);
      default:      prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/nvm_wel_latch.sv
module nvm_wel_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n_i,
  input  logic idle_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic arr_cmd_i,
  input  logic sr_done_i,
  output logic wel_o
);
  logic wel_q, wel_d;

  always_comb begin
    wel_d = wel_q;
    if (!wp_n_i || sr_done_i) begin
      wel_d = 1'b0;
    end else if (idle_i && (clr_i || arr_cmd_i)) begin
      wel_d = 1'b0;
    end else if (idle_i && set_i) begin
      wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_q <= 1'b0;
    else        wel_q <= wel_d;
  end

  assign wel_o = wel_q;

  AST_WP_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n_i |=> !wel_q); // R3
  AST_WEL_RISE_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(set_i && idle_i && wp_n_i)); // R2
  AST_BUSY_HOLDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_i && wp_n_i && !sr_done_i) |=> $stable(wel_q)); // R9
endmodule

// File: rtl/nvm_bp_store.sv
module nvm_bp_store
  import nvm_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_i,
  input  logic [1:0] new_bp_i,
  input  logic       cyc_busy_i,
  output prot_code_e bp_o,
  output logic       pend_o,
  output logic       done_o
);
  logic [1:0] bp_q, bp_d;
  logic [1:0] hold_q, hold_d;
  logic       pend_q, pend_d;
  logic       done;

  assign done = pend_q && !cyc_busy_i;

  always_comb begin
    bp_d   = bp_q;
    hold_d = hold_q;
    pend_d = pend_q;
    if (accept_i) begin
      hold_d = new_bp_i;
      pend_d = 1'b1;
    end else if (done) begin
      bp_d   = hold_q;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q   <= 2'b00;
      hold_q <= 2'b00;
      pend_q <= 1'b0;
    end else begin
      bp_q   <= bp_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  assign bp_o   = prot_code_e'(bp_q);
  assign pend_o = pend_q;
  assign done_o = done;

  AST_BP_FROZEN_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_busy_i |=> $stable(bp_q)); // R7
  AST_BP_MOVES_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> $stable(bp_q)); // R10
endmodule

// File: rtl/nvm_status_ctrl.sv
module nvm_status_ctrl
  import nvm_stat_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_set_en_i,
  input  logic              cmd_clr_en_i,
  input  logic              cmd_sr_wr_i,
  input  logic [1:0]        sr_bp_i,
  input  logic              cmd_arr_wr_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic              wp_n_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic [STAT_W-1:0] status_o,
  output logic              wr_allowed_o,
  output logic              chk_prot_o,
  output logic              sr_wr_start_o,
  output logic              arr_wr_start_o
);
  logic [1:0] rs_q;
  logic       rst_int_n;
  logic       launch_q, launch_d;
  logic       cyc_busy, wip, idle, wel, wr_ok;
  logic       pend, sr_done, arr_prot;
  prot_code_e bp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  assign cyc_busy = busy_i || launch_q;
  assign wip      = cyc_busy || pend;
  assign idle     = !wip;
  assign wr_ok    = wel && wp_n_i && idle;

  assign sr_wr_start_o  = cmd_sr_wr_i && wr_ok;
  assign arr_wr_start_o = cmd_arr_wr_i && wr_ok && !arr_prot;
  assign launch_d       = sr_wr_start_o || arr_wr_start_o;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) launch_q <= 1'b0;
    else            launch_q <= launch_d;
  end

  nvm_wel_latch u_wel (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wp_n_i    (wp_n_i),
    .idle_i    (idle),
    .set_i     (cmd_set_en_i),
    .clr_i     (cmd_clr_en_i),
    .arr_cmd_i (cmd_arr_wr_i),
    .sr_done_i (sr_done),
    .wel_o     (wel)
  );

  nvm_bp_store u_bp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept_i   (sr_wr_start_o),
    .new_bp_i   (sr_bp_i),
    .cyc_busy_i (cyc_busy),
    .bp_o       (bp),
    .pend_o     (pend),
    .done_o     (sr_done)
  );

  nvm_prot_decode #(.ADDR_W(ADDR_W)) u_dec_arr (
    .code_i (bp),
    .addr_i (arr_addr_i),
    .prot_o (arr_prot)
  );

  nvm_prot_decode #(.ADDR_W(ADDR_W)) u_dec_chk (
    .code_i (bp),
    .addr_i (chk_addr_i),
    .prot_o (chk_prot_o)
  );

  assign status_o     = {SR_ONES, bp, wel, wip};
  assign wr_allowed_o = wr_ok;

  AST_START_RAISES_WIP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sr_wr_start_o || arr_wr_start_o) |=> status_o[SR_WIP]); // R8
  AST_WP_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wp_n_i |-> !(sr_wr_start_o || arr_wr_start_o)); // R3
  AST_PROT_DROPS_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_arr_wr_i && arr_prot) |-> !arr_wr_start_o); // R5
  AST_ALL_CODE_PROTECTS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status_o[SR_BPLO+1:SR_BPLO] == 2'b11) |-> chk_prot_o); // R6
endmodule

// File: tb/nvm_status_ctrl_tb.sv
module nvm_status_ctrl_tb;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          set_en = 1'b0, clr_en = 1'b0, sr_wr = 1'b0, arr_wr = 1'b0;
  logic [1:0]    sr_bp = 2'b00;
  logic [AW-1:0] arr_addr = '0, chk_addr = '0;
  logic          wp_n = 1'b1, busy = 1'b0;
  logic [7:0]    status;
  logic          wr_allowed, chk_prot, sr_start, arr_start;

  int checks = 0;
  int errors = 0;
  logic started = 1'b0;
  int   bcnt = 0;

  always #10 clk = ~clk;

  nvm_status_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_set_en_i(set_en), .cmd_clr_en_i(clr_en),
    .cmd_sr_wr_i(sr_wr), .sr_bp_i(sr_bp),
    .cmd_arr_wr_i(arr_wr), .arr_addr_i(arr_addr),
    .wp_n_i(wp_n), .busy_i(busy), .chk_addr_i(chk_addr),
    .status_o(status), .wr_allowed_o(wr_allowed), .chk_prot_o(chk_prot),
    .sr_wr_start_o(sr_start), .arr_wr_start_o(arr_start)
  );

  // Model of the write-cycle timer: busy for four cycles after a start.
  always @(posedge clk) started <= sr_start | arr_start;
  always @(negedge clk) begin
    if (started) begin
      busy = 1'b1;
      bcnt = 4;
    end else if (bcnt > 0) begin
      bcnt = bcnt - 1;
      if (bcnt == 0) busy = 1'b0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(bit s, bit c, bit sw, bit aw, logic [1:0] d, logic [AW-1:0] a,
                       output bit got_sr, output bit got_arr);
    @(negedge clk);
    set_en = s; clr_en = c; sr_wr = sw; arr_wr = aw; sr_bp = d; arr_addr = a;
    #1;
    got_sr  = sr_start;
    got_arr = arr_start;
    @(negedge clk);
    set_en = 0; clr_en = 0; sr_wr = 0; arr_wr = 0;
    #2;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (status[0] === 1'b1 && n < 50) begin
      @(negedge clk); #2;
      n++;
    end
    check("R8", {31'd0, status[0]}, 0, "WIP clears after cycle");
  endtask

  task automatic probe(string req, logic [AW-1:0] a, bit exp);
    chk_addr = a;
    #1;
    check(req, {31'd0, chk_prot}, {31'd0, exp}, $sformatf("protected flag at %0h", a));
  endtask

  task automatic set_bp(logic [1:0] v);
    bit gs, ga;
    issue(1, 0, 0, 0, 2'b00, '0, gs, ga);
    issue(0, 0, 1, 0, v, '0, gs, ga);
    check("R4", {31'd0, gs}, 1, "status write start");
    wait_idle();
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #2;
    check("R1", {24'd0, status}, 32'hF0, "status after reset");
    check("R11", {31'd0, wr_allowed}, 0, "write permitted after reset");
    probe("R6", 8'hFF, 0);
  endtask

  task automatic t_enable();
    bit gs, ga;
    issue(1, 0, 0, 0, 2'b00, '0, gs, ga);
    check("R2", {24'd0, status}, 32'hF2, "set enable");
    check("R11", {31'd0, wr_allowed}, 1, "write permitted with WEL");
    issue(0, 1, 0, 0, 2'b00, '0, gs, ga);
    check("R2", {24'd0, status}, 32'hF0, "clear enable");
    issue(1, 0, 0, 0, 2'b00, '0, gs, ga);
    issue(1, 1, 0, 0, 2'b00, '0, gs, ga);
    check("R2", {24'd0, status}, 32'hF0, "clear wins over set");
  endtask

  task automatic t_wp();
    bit gs, ga;
    issue(1, 0, 0, 0, 2'b00, '0, gs, ga);
    @(negedge clk); wp_n = 0;
    @(negedge clk); #2;
    check("R3", {24'd0, status}, 32'hF0, "WEL cleared by pin");
    check("R11", {31'd0, wr_allowed}, 0, "write permitted with pin low");
    issue(1, 0, 0, 0, 2'b00, '0, gs, ga);
    check("R3", {24'd0, status}, 32'hF0, "set ignored with pin low");
    @(negedge clk); wp_n = 1;
    @(negedge clk); #2;
    check("R3", {24'd0, status}, 32'hF0, "WEL stays clear after pin rises");
  endtask

  task automatic t_sr_refused();
    bit gs, ga;
    issue(0, 0, 1, 0, 2'b11, '0, gs, ga);
    check("R4", {31'd0, gs}, 0, "status write without WEL");
    check("R4", {24'd0, status}, 32'hF0, "BP unchanged when refused");
  endtask

  task automatic t_sr_write();
    bit gs, ga;
    issue(1, 0, 0, 0, 2'b00, '0, gs, ga);
    issue(0, 0, 1, 0, 2'b10, '0, gs, ga);
    check("R4", {31'd0, gs}, 1, "status write accepted");
    check("R7", {24'd0, status}, 32'hF3, "old BP during cycle, WIP set");
    check("R11", {31'd0, wr_allowed}, 0, "write permitted during cycle");
    issue(0, 1, 0, 0, 2'b00, '0, gs, ga);
    check("R9", {24'd0, status}, 32'hF3, "clear enable ignored while busy");
    issue(0, 0, 0, 1, 2'b00, 8'h00, gs, ga);
    check("R9", {31'd0, ga}, 0, "array write ignored while busy");
    wait_idle();
    check("R7", {24'd0, status}, 32'hF8, "new BP and WEL clear at end");
    probe("R6", 8'h7F, 0);
    probe("R6", 8'h80, 1);
  endtask

  task automatic t_decode();
    set_bp(2'b01);
    check("R7", {24'd0, status}, 32'hF4, "BP 01 applied");
    probe("R6", 8'hBF, 0);
    probe("R6", 8'hC0, 1);
    probe("R6", 8'hFF, 1);
    set_bp(2'b11);
    check("R7", {24'd0, status}, 32'hFC, "BP 11 applied");
    probe("R6", 8'h00, 1);
    set_bp(2'b00);
    probe("R6", 8'hFF, 0);
  endtask

  task automatic t_arr();
    bit gs, ga;
    set_bp(2'b01);
    issue(1, 0, 0, 0, 2'b00, '0, gs, ga);
    issue(0, 0, 0, 1, 2'b00, 8'hC5, gs, ga);
    check("R5", {31'd0, ga}, 0, "protected array write dropped");
    check("R5", {24'd0, status}, 32'hF4, "WEL cleared by dropped write");
    issue(1, 0, 0, 0, 2'b00, '0, gs, ga);
    issue(0, 0, 0, 1, 2'b00, 8'h10, gs, ga);
    check("R5", {31'd0, ga}, 1, "unprotected array write starts");
    check("R8", {24'd0, status}, 32'hF5, "WIP set, WEL clear after array write");
    wait_idle();
    check("R5", {24'd0, status}, 32'hF4, "status after array write");
  endtask

  task automatic t_wp_nocancel();
    bit gs, ga;
    issue(1, 0, 0, 0, 2'b00, '0, gs, ga);
    issue(0, 0, 1, 0, 2'b10, '0, gs, ga);
    check("R10", {31'd0, gs}, 1, "status write started");
    @(negedge clk); wp_n = 0;
    @(negedge clk); #2;
    wait_idle();
    check("R10", {24'd0, status}, 32'hF8, "BP applied despite pin low");
    @(negedge clk); wp_n = 1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_enable();
    t_wp();
    t_sr_refused();
    t_sr_write();
    t_decode();
    t_arr();
    t_wp_nocancel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule